// File: doc/BRIEF.md
# Interrupt Latency Threshold Monitor

This block watches a small set of interrupt sources (by default two: an external one and a critical one). It measures how many cycles each source waits before the core redirects fetch to that source's vector. Each source gets two independent measures. The raw measure starts as soon as the request line is high, whatever the mask state. The pending measure runs only while the request is high and the source is enabled.

Every measure compares its running count against one shared, software-written threshold. When the count first becomes larger than the threshold, the measure emits a single-cycle event pulse, meant to feed a performance counter. A pending measure restarts from scratch when the source is masked before it is taken. A small threshold can therefore produce several pending events for one interrupt.

Top module: `irq_latency_monitor`

## Requirements
- R1: The raw measure of source s counts every cycle in which `irq_req[s]` is high, regardless of `irq_en[s]`; the first cycle with the request high is count 1.
- R2: The pending measure of source s counts only cycles in which both `irq_req[s]` and `irq_en[s]` are high; while `irq_en[s]` is low its event output stays low.
- R3: When a measure's count first exceeds the threshold T (the clock edge sampling the (T+1)-th counted cycle), its event output is high for exactly the following cycle. With a count of exactly T there is no event. At most one event is produced per interval.
- R4: A cycle with `fetch_redirect[s]` high ends both intervals of source s without an event in the next cycle. The measures then stay idle, producing no events, until their condition has gone low.
- R5: If the condition of a measure drops before any redirect, the measure returns to idle without an event, and a later assertion counts again from 1.
- R6: Masking a source in mid-interval and unmasking it later restarts the pending measure, which can then give a second event for the same interrupt.
- R7: Sources are independent: index 0 is the external source, index 1 the critical source, and stimulus on one never produces an event on the other.
- R8: The threshold is a TH_W-bit register loaded from `thr_wdata` in a cycle with `thr_we` high. The value is used from the next cycle on, including by intervals already running. It resets to TH_RST (default 8).
- R9: Latency counters saturate at all ones rather than wrapping. With a threshold of all ones (16'hFFFF) an event follows the 65536th counted cycle, and only once.
- R10: A synchronous active-high `rst` clears all measures and event outputs to zero and restores the threshold reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC (2) | Interrupt request lines, index 0 external, 1 critical |
| irq_en | input | NUM_SRC (2) | Per-source enable (unmasked) state |
| fetch_redirect | input | NUM_SRC (2) | Strobe: fetch redirected to this source's vector |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | TH_W (16) | Threshold write value |
| evt_raw | output | NUM_SRC (2) | Registered event pulse, raw-request measure |
| evt_pend | output | NUM_SRC (2) | Registered event pulse, enabled-pending measure |

## Verification
The embedded assertions check, on every cycle, the properties that hold locally. An event lasts one cycle, and none follows a redirect or a low condition. A masked source gives no pending event. A saturated count holds at all ones. A threshold write lands in the following cycle. An event count always exceeds the threshold seen one cycle earlier. Only the bench's scenarios can show the exact cycle at which each event appears for a given threshold, and the missing event when the count equals the threshold exactly. They also show the second pending event after a mask/unmask, the quiet hold after redirect while the request lingers, the independence of two overlapping sources, and the 65536-cycle saturation case.

// File: rtl/ilm_pkg.sv
package ilm_pkg;

  // Per-measure control state
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for the condition to rise
    ST_RUN  = 2'd1,  // counting latency cycles
    ST_HOLD = 2'd2   // taken; waiting for the condition to fall
  } meas_st_e;

  // Measure slots inside one source channel
  localparam int unsigned MEAS_RAW  = 0;
  localparam int unsigned MEAS_PEND = 1;
  localparam int unsigned NUM_MEAS  = 2;

endpackage

// File: rtl/ilm_thresh_reg.sv
module ilm_thresh_reg #(
  parameter int unsigned TH_W   = 16,
  parameter logic [TH_W-1:0] TH_RST = TH_W'(8)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [TH_W-1:0] wdata_i,
  output logic [TH_W-1:0] thr_o
);

  logic [TH_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst)       thr_q <= TH_RST;
    else if (we_i) thr_q <= wdata_i;
  end

  assign thr_o = thr_q;

  // R8: a write lands in the following cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (thr_q == $past(wdata_i)));

endmodule

// File: rtl/ilm_latency_timer.sv
module ilm_latency_timer
  import ilm_pkg::*;
#(
  parameter int unsigned TH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cond_i,   // condition that keeps the interval open
  input  logic            stop_i,   // fetch redirect for this source
  input  logic [TH_W-1:0] thr_i,
  output logic            evt_o
);

  localparam logic [TH_W-1:0] CNT_MAX = '1;
  localparam logic [TH_W:0]   ONE_EXT = {{TH_W{1'b0}}, 1'b1};

  meas_st_e        state_q, state_d;
  logic [TH_W-1:0] cnt_q, cnt_d;
  logic            fired_q, fired_d;
  logic            evt_q, evt_d;

  logic [TH_W:0]   base_ext;
  logic [TH_W:0]   next_ext;
  logic [TH_W-1:0] next_sat;
  logic            over;

  // Count after this cycle, computed one bit wider so that the
  // comparison against an all-ones threshold still works.
  always_comb begin
    base_ext = (state_q == ST_RUN) ? {1'b0, cnt_q} : '0;
    next_ext = base_ext + ONE_EXT;
    next_sat = next_ext[TH_W] ? CNT_MAX : next_ext[TH_W-1:0];
    over     = next_ext > {1'b0, thr_i};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fired_d = fired_q;
    evt_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cond_i && stop_i) begin
          state_d = ST_HOLD;
        end else if (cond_i) begin
          state_d = ST_RUN;
          cnt_d   = next_sat;
          fired_d = over;
          evt_d   = over;
        end
      end
      ST_RUN: begin
        if (stop_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
          fired_d = 1'b0;
        end else if (!cond_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          fired_d = 1'b0;
        end else begin
          cnt_d = next_sat;
          if (over && !fired_q) begin
            evt_d   = 1'b1;
            fired_d = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (!cond_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        fired_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      fired_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      evt_q   <= evt_d;
    end
  end

  assign evt_o = evt_q;

  // R3: an event lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);

  // R3: an event only follows a count above the threshold
  a_r3_above_thresh: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> ((cnt_q > $past(thr_i)) || (cnt_q == CNT_MAX)));

  // R4: no event right after a redirect
  a_r4_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !evt_q);

  // R4: redirect with the condition still high parks the measure
  a_r4_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (stop_i && cond_i) |=> (state_q == ST_HOLD));

  // R5: a low condition clears the interval without an event
  a_r5_cond_low_idle: assert property (@(posedge clk) disable iff (rst)
    !cond_i |=> (!evt_q && (cnt_q == '0)));

  // R9: a full counter stays full
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && cond_i && !stop_i && cnt_q == CNT_MAX)
      |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ilm_src_channel.sv
module ilm_src_channel
  import ilm_pkg::*;
#(
  parameter int unsigned TH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic            en_i,
  input  logic            redirect_i,
  input  logic [TH_W-1:0] thr_i,
  output logic            evt_raw_o,
  output logic            evt_pend_o
);

  logic [NUM_MEAS-1:0] cond;
  logic [NUM_MEAS-1:0] evt;

  assign cond[MEAS_RAW]  = req_i;
  assign cond[MEAS_PEND] = req_i & en_i;

  for (genvar m = 0; m < NUM_MEAS; m++) begin : g_meas
    ilm_latency_timer #(
      .TH_W (TH_W)
    ) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .cond_i (cond[m]),
      .stop_i (redirect_i),
      .thr_i  (thr_i),
      .evt_o  (evt[m])
    );
  end

  assign evt_raw_o  = evt[MEAS_RAW];
  assign evt_pend_o = evt[MEAS_PEND];

  // R2: a masked source gives no pending event
  a_r2_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !evt_pend_o);

  // R5: a dropped request gives no event of either kind
  a_r5_drop_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!evt_raw_o && !evt_pend_o));

endmodule

// File: rtl/irq_latency_monitor.sv
module irq_latency_monitor #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned TH_W    = 16,
  parameter logic [TH_W-1:0] TH_RST = TH_W'(8)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] fetch_redirect,
  input  logic               thr_we,
  input  logic [TH_W-1:0]    thr_wdata,
  output logic [NUM_SRC-1:0] evt_raw,
  output logic [NUM_SRC-1:0] evt_pend
);

  logic [TH_W-1:0] thr;

  ilm_thresh_reg #(
    .TH_W   (TH_W),
    .TH_RST (TH_RST)
  ) u_thr (
    .clk     (clk),
    .rst     (rst),
    .we_i    (thr_we),
    .wdata_i (thr_wdata),
    .thr_o   (thr)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ilm_src_channel #(
      .TH_W (TH_W)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .req_i      (irq_req[s]),
      .en_i       (irq_en[s]),
      .redirect_i (fetch_redirect[s]),
      .thr_i      (thr),
      .evt_raw_o  (evt_raw[s]),
      .evt_pend_o (evt_pend[s])
    );
  end

  // R10: outputs are quiet in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (evt_raw == '0 && evt_pend == '0));

endmodule

// File: tb/irq_latency_monitor_tb.sv
`timescale 1ns/1ps
module irq_latency_monitor_tb;

  localparam int NS = 2;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_req = '0;
  logic [NS-1:0] irq_en = '0;
  logic [NS-1:0] fetch_redirect = '0;
  logic          thr_we = 1'b0;
  logic [TW-1:0] thr_wdata = '0;
  logic [NS-1:0] evt_raw;
  logic [NS-1:0] evt_pend;

  always #2.5 clk = ~clk;

  irq_latency_monitor #(.NUM_SRC(NS), .TH_W(TW), .TH_RST(16'd8)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .fetch_redirect(fetch_redirect), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .evt_raw(evt_raw), .evt_pend(evt_pend));

  // src, threshold, cycles before enable, request length, redirect(1)/drop(0),
  // expected observation index of raw and pending events (0 = none)
  typedef struct packed {
    logic        src;
    logic [15:0] thr;
    logic [7:0]  en_dly;
    logic [7:0]  len;
    logic        redir;
    logic [7:0]  raw_at;
    logic [7:0]  pend_at;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd3, 8'd0, 8'd10, 1'b1, 8'd4,  8'd4 },
    '{1'b0, 16'd3, 8'd2, 8'd10, 1'b1, 8'd4,  8'd6 },
    '{1'b1, 16'd5, 8'd0, 8'd5,  1'b1, 8'd0,  8'd0 },
    '{1'b1, 16'd5, 8'd0, 8'd6,  1'b1, 8'd6,  8'd6 },
    '{1'b0, 16'd0, 8'd0, 8'd1,  1'b1, 8'd1,  8'd1 },
    '{1'b1, 16'd4, 8'd8, 8'd12, 1'b0, 8'd5,  8'd0 },
    '{1'b0, 16'd2, 8'd1, 8'd3,  1'b0, 8'd3,  8'd0 },
    '{1'b1, 16'd7, 8'd3, 8'd20, 1'b1, 8'd8,  8'd11}
  };

  int n_chk = 0;
  int n_fail = 0;
  int obs = 0;
  int raw_n [NS];
  int pend_n [NS];
  int raw_first [NS];
  int pend_first [NS];
  int pend_last [NS];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    obs = 0;
    for (int s = 0; s < NS; s++) begin
      raw_n[s] = 0; pend_n[s] = 0;
      raw_first[s] = 0; pend_first[s] = 0; pend_last[s] = 0;
    end
  endtask

  // one clock; outputs sampled at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    obs++;
    for (int s = 0; s < NS; s++) begin
      if (evt_raw[s]) begin
        raw_n[s]++;
        if (raw_first[s] == 0) raw_first[s] = obs;
      end
      if (evt_pend[s]) begin
        pend_n[s]++;
        if (pend_first[s] == 0) pend_first[s] = obs;
        pend_last[s] = obs;
      end
    end
  endtask

  task automatic idle(input int n);
    irq_req = '0; irq_en = '0; fetch_redirect = '0; thr_we = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_thr(input logic [TW-1:0] v);
    thr_we = 1'b1; thr_wdata = v;
    tick();
    thr_we = 1'b0;
  endtask

  task automatic run_case(input vec_t v, input int k);
    int s;
    s = int'(v.src);
    set_thr(v.thr);
    idle(2);
    clear_mon();
    for (int i = 0; i < int'(v.len); i++) begin
      irq_req[s] = 1'b1;
      irq_en[s]  = (i >= int'(v.en_dly));
      tick();
    end
    if (v.redir) begin
      fetch_redirect[s] = 1'b1;
      tick();
    end else begin
      irq_req[s] = 1'b0; irq_en[s] = 1'b0;
      tick();
    end
    idle(3);
    chk($sformatf("R1 raw event count case %0d", k), raw_n[s], (v.raw_at != 0) ? 1 : 0);
    chk($sformatf("R3 raw event cycle case %0d", k), raw_first[s], int'(v.raw_at));
    chk($sformatf("R2 pending event count case %0d", k), pend_n[s], (v.pend_at != 0) ? 1 : 0);
    chk($sformatf("R2 pending event cycle case %0d", k), pend_first[s], int'(v.pend_at));
    chk($sformatf("R7 other source quiet case %0d", k),
        raw_n[1-s] + pend_n[1-s], 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_mon();
    @(negedge clk);
    rst = 1'b1;
    tick(); tick(); tick();
    chk("R10 raw events low in reset", int'(evt_raw), 0);
    chk("R10 pending events low in reset", int'(evt_pend), 0);
    rst = 1'b0;
    idle(1);

    // R8/R10: reset threshold of 8 -> event after the 9th cycle
    clear_mon();
    for (int i = 0; i < 12; i++) begin irq_req[0] = 1'b1; tick(); end
    fetch_redirect[0] = 1'b1; tick();
    idle(3);
    chk("R8 reset threshold raw event cycle", raw_first[0], 9);
    chk("R8 reset threshold raw event count", raw_n[0], 1);

    // table walk
    for (int k = 0; k < NV; k++) run_case(VECS[k], k);

    // R6: mask and unmask restarts the pending measure
    set_thr(16'd2); idle(2); clear_mon();
    for (int i = 0; i < 14; i++) begin
      irq_req[0] = 1'b1;
      irq_en[0]  = (i < 5) || (i >= 7);
      fetch_redirect[0] = (i == 13);
      tick();
    end
    idle(3);
    chk("R6 pending events after unmask", pend_n[0], 2);
    chk("R6 first pending event cycle", pend_first[0], 3);
    chk("R6 second pending event cycle", pend_last[0], 10);
    chk("R3 raw single event per interval", raw_n[0], 1);

    // R4: request lingers after redirect without a new event
    set_thr(16'd1); idle(2); clear_mon();
    for (int i = 0; i < 10; i++) begin
      irq_req[1] = 1'b1;
      fetch_redirect[1] = (i == 3);
      tick();
    end
    idle(3);
    chk("R4 events with request held after redirect", raw_n[1], 1);
    chk("R4 raw event cycle before redirect", raw_first[1], 2);

    // R7: overlapping sources
    set_thr(16'd3); idle(2); clear_mon();
    for (int i = 0; i < 12; i++) begin
      irq_req[0] = (i <= 10);
      fetch_redirect[0] = (i == 10);
      irq_req[1] = (i >= 2);
      fetch_redirect[1] = (i == 11);
      tick();
    end
    idle(3);
    chk("R7 external raw event cycle", raw_first[0], 4);
    chk("R7 critical raw event cycle", raw_first[1], 6);
    chk("R7 external event count", raw_n[0], 1);
    chk("R7 critical event count", raw_n[1], 1);

    // R8: threshold written during a running interval
    set_thr(16'd10); idle(2); clear_mon();
    for (int i = 0; i < 10; i++) begin
      irq_req[0] = 1'b1;
      thr_we = (i == 3); thr_wdata = 16'd2;
      fetch_redirect[0] = (i == 9);
      tick();
    end
    idle(3);
    chk("R8 new threshold applies mid interval", raw_first[0], 5);

    // R9: all-ones threshold with a saturating counter
    set_thr(16'hFFFF); idle(2); clear_mon();
    irq_req[0] = 1'b1;
    for (int i = 0; i < 66000; i++) tick();
    fetch_redirect[0] = 1'b1; tick();
    idle(3);
    chk("R9 saturated event cycle", raw_first[0], 65536);
    chk("R9 saturated event count", raw_n[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule